// File: doc/BRIEF.md
# Two-Way Processor Mailbox

This block joins a host CPU's I/O bus to a second processor (an I/O processor, called the device here) through one byte-wide holding register per direction. The side that sends writes its outbound byte and a full flag goes up. The other side sees that flag in its status register, reads the byte, and the flag drops. When the device posts a byte for the host, an interrupt request to the host also goes up. The request stays up until the host fetches that byte.

The host reaches the block through an address compare against a base address given as a parameter. Several copies can therefore sit at different I/O addresses on the same bus. The lowest address bit chooses between the data register and the status register. The device side has a plain select and a register-choice bit. Both sides run on one clock. Every read and write strobe is edge-detected, so a strobe held for many cycles counts as a single access.

Top module: `cpu_mailbox`

## Requirements
- R1: After reset both full flags, both overrun bits and `h_irq` are 0, and both data registers hold 0.
- R2: A host write to the data address (`h_addr` equal to `HOST_BASE`, bit 0 = 0) stores the byte in the host-to-device register and sets its full flag. A device data read (`d_sel`=1, `d_reg`=0) returns that byte.
- R3: A device data write (`d_sel`=1, `d_reg`=0, `d_wr`) stores the byte in the device-to-host register, sets its full flag and raises `h_irq`. A host data read returns that byte.
- R4: A data read by the receiving side clears that direction's full flag. A host data read also drops `h_irq`.
- R5: Status byte (host: `h_addr` bit 0 = 1; device: `d_reg`=1). Bit 0 shows that this side's outbound register is full. Bit 1 shows that inbound data is waiting. Bit 2 is this side's overrun. Bits 7..3 read 0.
- R6: A write while the sender's own full flag is set replaces the byte and sets that sender's sticky overrun bit. A status read by that sender returns the bit set and clears it afterwards.
- R7: A strobe held high for several cycles acts only once. A long write does not cause an overrun, and a long read clears the flag once.
- R8: Host accesses whose upper address bits differ from `HOST_BASE` change nothing and read as 0.
- R9: When the sender writes in the same cycle as the receiver reads, the new byte is kept with the flag set, and no overrun is recorded.
- R10: Status reads leave both full flags and `h_irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_cs | input | 1 | Host I/O cycle valid |
| h_addr | input | ADDR_W | Host I/O address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wdata | input | DATA_W | Host write data |
| h_rdata | output | DATA_W | Host read data (data or status), 0 when not addressed |
| h_irq | output | 1 | Interrupt request to the host |
| d_sel | input | 1 | Device access select |
| d_reg | input | 1 | Device register choice: 0 data, 1 status |
| d_wr | input | 1 | Device write strobe |
| d_rd | input | 1 | Device read strobe |
| d_wdata | input | DATA_W | Device write data |
| d_rdata | output | DATA_W | Device read data (data or status), 0 when not selected |

## Verification
Ordered exchanges are tried in both directions: write, peer status, read, then status again. Each step shows whether the flags track the data and whether the interrupt follows only device writes. Back-to-back writes with no read in between separate overwrite-with-overrun from a silent drop. A status read before the data read and another after it show that the sticky bit clears only on the sender's status read. Strobes held for several cycles tell edge detection apart from level sensing. A write landing in the same cycle as a read checks the write-wins rule. A non-matching host address shows that the decode keeps foreign cycles out.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    // status byte bit positions, shared by both sides
    localparam int STAT_OUT_FULL = 0;
    localparam int STAT_IN_AVAIL = 1;
    localparam int STAT_OVERRUN  = 2;

    // strobe event indexes
    localparam int EV_HWR   = 0;
    localparam int EV_HRD   = 1;
    localparam int EV_HSTAT = 2;
    localparam int EV_DWR   = 3;
    localparam int EV_DRD   = 4;
    localparam int EV_DSTAT = 5;
    localparam int EV_COUNT = 6;

    // channel indexes
    localparam int CH_H2D = 0;
    localparam int CH_D2H = 1;
endpackage

// File: rtl/mbx_edge.sv
module mbx_edge #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_evt,
    input  logic              stat_evt,
    output logic [DATA_W-1:0] data,
    output logic              full,
    output logic              ovr
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              ovr;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stat_evt) st_d.ovr  = 1'b0;
        if (rd_evt)   st_d.full = 1'b0;
        if (wr_evt) begin
            st_d.data = wdata;
            st_d.full = 1'b1;
            if (st_q.full && !rd_evt) st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data = st_q.data;
    assign full = st_q.full;
    assign ovr  = st_q.ovr;
endmodule

// File: rtl/cpu_mailbox.sv
module cpu_mailbox #(
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] HOST_BASE = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_cs,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    output logic              h_irq,
    input  logic              d_sel,
    input  logic              d_reg,
    input  logic              d_wr,
    input  logic              d_rd,
    input  logic [DATA_W-1:0] d_wdata,
    output logic [DATA_W-1:0] d_rdata
);
    import mbx_pkg::*;

    localparam int NCH = 2;

    typedef struct packed {
        logic irq;
    } top_t;

    logic                host_hit;
    logic [EV_COUNT-1:0] lvl, ev;
    logic [NCH-1:0]      wr_ev, rd_ev, st_ev, full, ovr;
    logic [DATA_W-1:0]   wd   [NCH];
    logic [DATA_W-1:0]   held [NCH];
    logic [DATA_W-1:0]   h_stat, d_stat;
    top_t                t_d, t_q;

    // host address decode: upper bits pick the instance, bit 0 the register
    assign host_hit = h_cs && (h_addr[ADDR_W-1:1] == HOST_BASE[ADDR_W-1:1]);

    always_comb begin
        lvl           = '0;
        lvl[EV_HWR]   = host_hit && h_wr && !h_addr[0];
        lvl[EV_HRD]   = host_hit && h_rd && !h_addr[0];
        lvl[EV_HSTAT] = host_hit && h_rd &&  h_addr[0];
        lvl[EV_DWR]   = d_sel && d_wr && !d_reg;
        lvl[EV_DRD]   = d_sel && d_rd && !d_reg;
        lvl[EV_DSTAT] = d_sel && d_rd &&  d_reg;
    end

    mbx_edge #(.N(EV_COUNT)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl),
        .rise (ev)
    );

    // per-direction wiring: sender write, receiver read, sender status read
    assign wr_ev[CH_H2D] = ev[EV_HWR];
    assign rd_ev[CH_H2D] = ev[EV_DRD];
    assign st_ev[CH_H2D] = ev[EV_HSTAT];
    assign wd[CH_H2D]    = h_wdata;
    assign wr_ev[CH_D2H] = ev[EV_DWR];
    assign rd_ev[CH_D2H] = ev[EV_HRD];
    assign st_ev[CH_D2H] = ev[EV_DSTAT];
    assign wd[CH_D2H]    = d_wdata;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        mbx_channel #(.DATA_W(DATA_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_evt  (wr_ev[c]),
            .wdata   (wd[c]),
            .rd_evt  (rd_ev[c]),
            .stat_evt(st_ev[c]),
            .data    (held[c]),
            .full    (full[c]),
            .ovr     (ovr[c])
        );
    end

    // host interrupt: raised by device post, dropped by host data read
    always_comb begin
        t_d = t_q;
        if (ev[EV_HRD]) t_d.irq = 1'b0;
        if (ev[EV_DWR]) t_d.irq = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign h_irq = t_q.irq;

    always_comb begin
        h_stat                = '0;
        h_stat[STAT_OUT_FULL] = full[CH_H2D];
        h_stat[STAT_IN_AVAIL] = full[CH_D2H];
        h_stat[STAT_OVERRUN]  = ovr[CH_H2D];
        d_stat                = '0;
        d_stat[STAT_OUT_FULL] = full[CH_D2H];
        d_stat[STAT_IN_AVAIL] = full[CH_H2D];
        d_stat[STAT_OVERRUN]  = ovr[CH_D2H];
        h_rdata = host_hit ? (h_addr[0] ? h_stat : held[CH_D2H]) : '0;
        d_rdata = d_sel    ? (d_reg    ? d_stat : held[CH_H2D]) : '0;
    end
endmodule

// File: rtl/cpu_mailbox_chk.sv
module cpu_mailbox_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] ev,
    input logic [1:0] full,
    input logic [1:0] ovr,
    input logic       h_irq
);
    // ev bits: 0 host wr, 1 host data rd, 2 host stat rd, 3 dev wr, 4 dev data rd, 5 dev stat rd
    a_r2_host_write_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        ev[0] |=> full[0]);
    a_r3_dev_write_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ev[3] |=> (h_irq && full[1]));
    a_r4_dev_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[4] && !ev[0]) |=> !full[0]);
    a_r4_host_read_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[1] && !ev[3]) |=> (!h_irq && !full[1]));
    a_r6_overrun_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[0] && full[0] && !ev[4]) |=> ovr[0]);
    a_r7_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        ev[0] |=> !ev[0]);
    a_r10_status_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[2] && !ev[0] && !ev[4]) |=> $stable(full[0]));
endmodule

bind cpu_mailbox cpu_mailbox_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .ev   (ev),
    .full (full),
    .ovr  (ovr),
    .h_irq(h_irq)
);

// File: tb/cpu_mailbox_tb.sv
module cpu_mailbox_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       h_cs = 0, h_wr = 0, h_rd = 0, d_sel = 0, d_reg = 0, d_wr = 0, d_rd = 0;
    logic [7:0] h_addr = 0, h_wdata = 0, d_wdata = 0;
    logic [7:0] h_rdata, d_rdata;
    logic       h_irq;
    int         checks = 0, errors = 0;
    bit         done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_mailbox u_dut (
        .clk(clk), .rst_n(rst_n), .h_cs(h_cs), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq), .d_sel(d_sel), .d_reg(d_reg),
        .d_wr(d_wr), .d_rd(d_rd), .d_wdata(d_wdata), .d_rdata(d_rdata)
    );

    // {req[3:0], side(0 host,1 dev), wr, addr[7:0], wdata[7:0], expected read[7:0], expected irq}
    localparam logic [30:0] VEC [NV] = '{
        {4'd1,  1'b0, 1'b0, 8'h41, 8'h00, 8'h00, 1'b0}, // R1 host status clear
        {4'd2,  1'b0, 1'b1, 8'h40, 8'hA5, 8'h00, 1'b0}, // R2 host posts A5
        {4'd5,  1'b0, 1'b0, 8'h41, 8'h00, 8'h01, 1'b0}, // R5 host sees outbound full
        {4'd5,  1'b1, 1'b0, 8'h01, 8'h00, 8'h02, 1'b0}, // R5 device sees inbound
        {4'd2,  1'b1, 1'b0, 8'h00, 8'h00, 8'hA5, 1'b0}, // R2 device reads A5
        {4'd4,  1'b1, 1'b0, 8'h01, 8'h00, 8'h00, 1'b0}, // R4 flag cleared
        {4'd3,  1'b1, 1'b1, 8'h00, 8'h3C, 8'h00, 1'b1}, // R3 device posts, irq up
        {4'd10, 1'b0, 1'b0, 8'h41, 8'h00, 8'h02, 1'b1}, // R10 status read keeps irq
        {4'd3,  1'b0, 1'b0, 8'h40, 8'h00, 8'h3C, 1'b0}, // R3 host reads 3C, R4 irq drops
        {4'd4,  1'b0, 1'b0, 8'h41, 8'h00, 8'h00, 1'b0}, // R4 inbound cleared
        {4'd6,  1'b0, 1'b1, 8'h40, 8'h11, 8'h00, 1'b0}, // R6 first write
        {4'd6,  1'b0, 1'b1, 8'h40, 8'h22, 8'h00, 1'b0}, // R6 overwrite
        {4'd6,  1'b0, 1'b0, 8'h41, 8'h00, 8'h05, 1'b0}, // R6 overrun seen
        {4'd6,  1'b0, 1'b0, 8'h41, 8'h00, 8'h01, 1'b0}, // R6 overrun cleared
        {4'd6,  1'b1, 1'b0, 8'h00, 8'h00, 8'h22, 1'b0}, // R6 newest byte kept
        {4'd8,  1'b0, 1'b1, 8'h50, 8'h99, 8'h00, 1'b0}, // R8 foreign write
        {4'd8,  1'b0, 1'b0, 8'h50, 8'h00, 8'h00, 1'b0}, // R8 foreign read is 0
        {4'd8,  1'b1, 1'b0, 8'h01, 8'h00, 8'h00, 1'b0}  // R8 nothing arrived
    };

    task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        h_cs = 0; h_wr = 0; h_rd = 0; d_sel = 0; d_wr = 0; d_rd = 0;
    endtask

    // one access; held = number of rising edges the strobe spans
    task automatic op(input int req, input bit side, input bit wr, input logic [7:0] addr,
                      input logic [7:0] wdata, input logic [7:0] exp, input bit chk_rd, input int held);
        @(negedge clk);
        if (!side) begin
            h_cs = 1; h_addr = addr; h_wdata = wdata; h_wr = wr; h_rd = !wr;
        end else begin
            d_sel = 1; d_reg = addr[0]; d_wdata = wdata; d_wr = wr; d_rd = !wr;
        end
        #1;
        if (!wr && chk_rd) chk(req, side ? d_rdata : h_rdata, exp);
        for (int i = 0; i < held; i++) @(posedge clk);
        @(negedge clk);
        idle();
        @(posedge clk);
    endtask

    task automatic rd_chk(input int req, input bit side, input logic [7:0] addr, input logic [7:0] exp);
        op(req, side, 1'b0, addr, 8'h00, exp, 1'b1, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1 reset state
        @(negedge clk);
        chk(1, {7'd0, h_irq}, 8'h00);
        rd_chk(1, 1'b1, 8'h01, 8'h00);
        rd_chk(1, 1'b1, 8'h00, 8'h00);

        for (int v = 0; v < NV; v++) begin
            op(int'(VEC[v][30:27]), VEC[v][26], VEC[v][25], VEC[v][24:17], VEC[v][16:9],
               VEC[v][8:1], 1'b1, 1);
            @(negedge clk);
            chk(int'(VEC[v][30:27]), {7'd0, h_irq}, {7'd0, VEC[v][0]});
        end

        // R7 long write: held 5 edges, no overrun
        op(7, 1'b0, 1'b1, 8'h40, 8'h77, 8'h00, 1'b0, 5);
        rd_chk(7, 1'b0, 8'h41, 8'h01);
        // R7 long device read clears once, returns 77
        op(7, 1'b1, 1'b0, 8'h00, 8'h00, 8'h77, 1'b1, 4);
        rd_chk(7, 1'b0, 8'h41, 8'h00);
        // R7 long device write: irq up once, host read drops it
        op(7, 1'b1, 1'b1, 8'h00, 8'h5A, 8'h00, 1'b0, 4);
        rd_chk(7, 1'b1, 8'h01, 8'h01);
        rd_chk(7, 1'b0, 8'h40, 8'h5A);
        @(negedge clk);
        chk(7, {7'd0, h_irq}, 8'h00);

        // R9 write and read in the same cycle
        op(9, 1'b0, 1'b1, 8'h40, 8'h01, 8'h00, 1'b0, 1);
        @(negedge clk);
        h_cs = 1; h_addr = 8'h40; h_wdata = 8'h02; h_wr = 1;
        d_sel = 1; d_reg = 0; d_rd = 1;
        #1 chk(9, d_rdata, 8'h01);
        @(posedge clk);
        @(negedge clk) idle();
        @(posedge clk);
        rd_chk(9, 1'b0, 8'h41, 8'h01);
        rd_chk(9, 1'b1, 8'h00, 8'h02);

        // R1 mid-run reset with a flag and irq set
        op(1, 1'b1, 1'b1, 8'h00, 8'hEE, 8'h00, 1'b0, 1);
        @(negedge clk) rst_n = 0;
        @(posedge clk);
        @(negedge clk) rst_n = 1;
        chk(1, {7'd0, h_irq}, 8'h00);
        rd_chk(1, 1'b0, 8'h41, 8'h00);
        rd_chk(1, 1'b0, 8'h40, 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule